// File: doc/BRIEF.md
# ADC Input Conditioning Channel

This block sits between a 14-bit signed converter stream and an 18-bit signed internal datapath. On the input side each valid converter sample is first widened into the upper bits of an 18-bit word. It is then scaled by a programmable signed gain and moved by a programmable signed DC offset. Last, it is smoothed by a moving average whose length can be selected at run time. The output carries the conditioned value with a sample-valid strobe after a fixed three-cycle pipeline.

A separate narrowing path takes 18-bit internal values with their own valid strobe. It rounds each one to a 14-bit code for a DAC and clips it at the 14-bit limits. The two paths share only the clock and reset.

Top module: `adc_cond_chan`

## Requirements
- R1: While `rst_n` is low, `out_valid` and `dac_out_valid` are 0 and `out_data` and `dac_out` are 0. The smoothing history and its running sums are cleared to zero.
- R2: Widening places the 14-bit sample in bits 17..4 of the 18-bit word and sets bits 3..0 to zero, so the sign is kept. With gain 1.0, offset 0 and length code 0, `out_data` equals `in_sample` times 16.
- R3: `gain` is a signed 18-bit value with 14 fraction bits, so 16384 means 1.0. The 36-bit product is rounded to the nearest integer, with exact halves going toward positive infinity. The rounded value is then clipped to [-131072, 131071].
- R4: `offset` is a signed 18-bit value added to the gained sample. The sum is clipped to [-131072, 131071].
- R5: `avg_len` code k (0..3) averages the 2^k most recent valid samples. The window sum is shifted right arithmetically by k, which rounds toward negative infinity. Window slots not yet filled since reset count as zero.
- R6: The smoothing history advances only on a valid sample. With no valid sample, `out_data` holds its value, and so it does when `avg_len` changes.
- R7: `out_valid` is high exactly in the cycle three clock edges after an edge at which `in_valid` was sampled high, and low otherwise.
- R8: The DAC path computes (x + 8) shifted right arithmetically by 4 and clips the result to [-8192, 8191]. `dac_out_valid` and the new `dac_out` appear one edge after `dac_in_valid` is sampled high.
- R9: `dac_out` holds its value while `dac_in_valid` is low. `dac_out_valid` is low in any cycle not preceded by a sampled `dac_in_valid`.
- R10: Running sums for all four lengths are kept at the same time. The first valid sample after a change of `avg_len` therefore yields the full average over the new length's most recent samples.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| in_valid | input | 1 | Converter sample strobe |
| in_sample | input | 14 | Signed converter sample |
| gain | input | 18 | Signed gain, 14 fraction bits |
| offset | input | 18 | Signed DC offset in 18-bit units |
| avg_len | input | 2 | Averaging length code, length = 2^code |
| out_valid | output | 1 | Conditioned sample strobe |
| out_data | output | 18 | Conditioned, smoothed sample |
| dac_in_valid | input | 1 | Internal value strobe for DAC path |
| dac_in | input | 18 | Signed internal value |
| dac_out_valid | output | 1 | DAC code strobe |
| dac_out | output | 14 | Signed rounded, clipped DAC code |

## Verification
The bench builds the block with its default parameters: a 14-bit converter, an 18-bit datapath, 14 gain fraction bits and lengths up to eight samples. With these values a 4.0 gain on full-scale codes reaches both gain clip limits, and an offset of about 10000 pushes near-full-scale samples past either rail. The eight-deep history allows partially filled windows and switches between all four lengths. Values near the 18-bit extremes drive the DAC rounding carry into clipping, and small odd values exercise rounding on both sides of zero.

// File: rtl/adc_cond_pkg.sv
package adc_cond_pkg;
  // Default geometry of the conditioning channel
  localparam int unsigned CONV_W_DEF   = 14;
  localparam int unsigned CORE_W_DEF   = 18;
  localparam int unsigned GFRAC_DEF    = 14;
  localparam int unsigned LEN_LOG_DEF  = 3;
endpackage

// File: rtl/adc_cond_cal.sv
module adc_cond_cal #(
  parameter int unsigned CONV_W = adc_cond_pkg::CONV_W_DEF,
  parameter int unsigned CORE_W = adc_cond_pkg::CORE_W_DEF,
  parameter int unsigned GFRAC  = adc_cond_pkg::GFRAC_DEF
) (
  input  logic                     clk,
  input  logic                     rst_n,
  input  logic                     s_valid,
  input  logic signed [CONV_W-1:0] s_code,
  input  logic signed [CORE_W-1:0] k_gain,
  input  logic signed [CORE_W-1:0] k_offs,
  output logic                     m_valid,
  output logic signed [CORE_W-1:0] m_data
);
  localparam int unsigned PAD = CORE_W - CONV_W;
  localparam int unsigned PW  = 2 * CORE_W;
  localparam logic signed [PW:0] RND    = (PW+1)'(2**(GFRAC-1));
  localparam logic signed [PW:0] LIM_HI = (PW+1)'(2**(CORE_W-1) - 1);
  localparam logic signed [PW:0] LIM_LO = ~LIM_HI;
  localparam logic signed [CORE_W-1:0] UNITY = CORE_W'(2**GFRAC);

  function automatic logic signed [CORE_W-1:0] f_widen(input logic signed [CONV_W-1:0] a);
    return {a, {PAD{1'b0}}};
  endfunction

  function automatic logic signed [CORE_W-1:0] f_clip(input logic signed [PW:0] v);
    if (v > LIM_HI) return CORE_W'(LIM_HI);
    if (v < LIM_LO) return CORE_W'(LIM_LO);
    return CORE_W'(v);
  endfunction

  function automatic logic signed [CORE_W-1:0] f_scale(input logic signed [CORE_W-1:0] x,
                                                        input logic signed [CORE_W-1:0] g);
    logic signed [PW-1:0] prod;
    logic signed [PW:0]   acc;
    prod = PW'(x) * PW'(g);
    acc  = ((PW+1)'(prod) + RND) >>> GFRAC;
    return f_clip(acc);
  endfunction

  function automatic logic signed [CORE_W-1:0] f_shift_dc(input logic signed [CORE_W-1:0] x,
                                                           input logic signed [CORE_W-1:0] o);
    return f_clip((PW+1)'(x) + (PW+1)'(o));
  endfunction

  logic signed [CORE_W-1:0] widened;
  logic signed [CORE_W-1:0] scaled_q;
  logic                     scaled_v;

  assign widened = f_widen(s_code);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      scaled_q <= '0;
      scaled_v <= 1'b0;
      m_data   <= '0;
      m_valid  <= 1'b0;
    end else begin
      scaled_v <= s_valid;
      if (s_valid) scaled_q <= f_scale(widened, k_gain);
      m_valid <= scaled_v;
      if (scaled_v) m_data <= f_shift_dc(scaled_q, k_offs);
    end
  end

  // R3: unity gain leaves the widened sample untouched
  p_unity_gain_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (s_valid && k_gain == UNITY) |=> (scaled_q == $past(widened)));

  // R4: zero offset passes the scaled value
  p_zero_offset_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (scaled_v && k_offs == '0) |=> (m_data == $past(scaled_q)));
endmodule

// File: rtl/adc_cond_smooth.sv
module adc_cond_smooth #(
  parameter int unsigned CORE_W  = adc_cond_pkg::CORE_W_DEF,
  parameter int unsigned LEN_LOG = adc_cond_pkg::LEN_LOG_DEF,
  localparam int unsigned SEL_W  = $clog2(LEN_LOG + 1)
) (
  input  logic                     clk,
  input  logic                     rst_n,
  input  logic                     s_valid,
  input  logic signed [CORE_W-1:0] s_data,
  input  logic [SEL_W-1:0]         len_sel,
  output logic                     m_valid,
  output logic signed [CORE_W-1:0] m_data
);
  localparam int unsigned DEPTH = 1 << LEN_LOG;
  localparam int unsigned SUM_W = CORE_W + LEN_LOG;

  logic signed [CORE_W-1:0] hist    [DEPTH];
  logic signed [SUM_W-1:0]  sum_q   [LEN_LOG+1];
  logic signed [SUM_W-1:0]  sum_nx  [LEN_LOG+1];
  logic signed [SUM_W-1:0]  picked;
  logic signed [CORE_W-1:0] mean_nx;

  for (genvar k = 0; k <= LEN_LOG; k++) begin : g_len
    localparam int unsigned TAIL = (1 << k) - 1;
    assign sum_nx[k] = sum_q[k] + SUM_W'(s_data) - SUM_W'(hist[TAIL]);
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)       sum_q[k] <= '0;
      else if (s_valid) sum_q[k] <= sum_nx[k];
    end
  end

  always_comb begin
    picked = sum_nx[0];
    for (int k = 0; k <= LEN_LOG; k++)
      if (len_sel == SEL_W'(k)) picked = sum_nx[k];
    mean_nx = CORE_W'(picked >>> len_sel);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      for (int i = 0; i < DEPTH; i++) hist[i] <= '0;
      m_data  <= '0;
      m_valid <= 1'b0;
    end else begin
      m_valid <= s_valid;
      if (s_valid) begin
        hist[0] <= s_data;
        for (int i = 1; i < DEPTH; i++) hist[i] <= hist[i-1];
        m_data <= mean_nx;
      end
    end
  end

  // R5: length one passes each sample straight through
  p_len_one_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (s_valid && len_sel == '0) |=> (m_data == $past(s_data)));

  // R6: no valid sample, no change
  p_hold_idle_r6: assert property (@(posedge clk) disable iff (!rst_n)
    !s_valid |=> $stable(m_data));
endmodule

// File: rtl/adc_cond_narrow.sv
module adc_cond_narrow #(
  parameter int unsigned CONV_W = adc_cond_pkg::CONV_W_DEF,
  parameter int unsigned CORE_W = adc_cond_pkg::CORE_W_DEF
) (
  input  logic                     clk,
  input  logic                     rst_n,
  input  logic                     s_valid,
  input  logic signed [CORE_W-1:0] s_data,
  output logic                     m_valid,
  output logic signed [CONV_W-1:0] m_code
);
  localparam int unsigned DROP = CORE_W - CONV_W;
  localparam int unsigned XW   = CORE_W + 1;
  localparam logic signed [XW-1:0] RND    = XW'(2**(DROP-1));
  localparam logic signed [XW-1:0] CODE_HI = XW'(2**(CONV_W-1) - 1);
  localparam logic signed [XW-1:0] CODE_LO = ~CODE_HI;
  localparam logic signed [CORE_W-1:0] CORE_MAX = CORE_W'(2**(CORE_W-1) - 1);
  localparam logic signed [CONV_W-1:0] OUT_MAX  = CONV_W'(2**(CONV_W-1) - 1);

  function automatic logic signed [CONV_W-1:0] f_narrow(input logic signed [CORE_W-1:0] x);
    logic signed [XW-1:0] v;
    v = (XW'(x) + RND) >>> DROP;
    if (v > CODE_HI) return CONV_W'(CODE_HI);
    if (v < CODE_LO) return CONV_W'(CODE_LO);
    return CONV_W'(v);
  endfunction

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      m_code  <= '0;
      m_valid <= 1'b0;
    end else begin
      m_valid <= s_valid;
      if (s_valid) m_code <= f_narrow(s_data);
    end
  end

  // R8: rounding carry at the top of range clips rather than wraps
  p_dac_clip_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (s_valid && s_data == CORE_MAX) |=> (m_code == OUT_MAX));

  // R9: code is held when no value arrives
  p_dac_hold_r9: assert property (@(posedge clk) disable iff (!rst_n)
    !s_valid |=> ($stable(m_code) && !m_valid));
endmodule

// File: rtl/adc_cond_chan.sv
module adc_cond_chan #(
  parameter int unsigned CONV_W  = adc_cond_pkg::CONV_W_DEF,
  parameter int unsigned CORE_W  = adc_cond_pkg::CORE_W_DEF,
  parameter int unsigned GFRAC   = adc_cond_pkg::GFRAC_DEF,
  parameter int unsigned LEN_LOG = adc_cond_pkg::LEN_LOG_DEF,
  localparam int unsigned SEL_W  = $clog2(LEN_LOG + 1)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              in_valid,
  input  logic [CONV_W-1:0] in_sample,
  input  logic [CORE_W-1:0] gain,
  input  logic [CORE_W-1:0] offset,
  input  logic [SEL_W-1:0]  avg_len,
  output logic              out_valid,
  output logic [CORE_W-1:0] out_data,
  input  logic              dac_in_valid,
  input  logic [CORE_W-1:0] dac_in,
  output logic              dac_out_valid,
  output logic [CONV_W-1:0] dac_out
);
  logic                     cal_valid;
  logic signed [CORE_W-1:0] cal_data;
  logic signed [CORE_W-1:0] avg_data;
  logic signed [CONV_W-1:0] dac_code;

  adc_cond_cal #(.CONV_W(CONV_W), .CORE_W(CORE_W), .GFRAC(GFRAC)) u_cal (
    .clk     (clk),
    .rst_n   (rst_n),
    .s_valid (in_valid),
    .s_code  ($signed(in_sample)),
    .k_gain  ($signed(gain)),
    .k_offs  ($signed(offset)),
    .m_valid (cal_valid),
    .m_data  (cal_data)
  );

  adc_cond_smooth #(.CORE_W(CORE_W), .LEN_LOG(LEN_LOG)) u_avg (
    .clk     (clk),
    .rst_n   (rst_n),
    .s_valid (cal_valid),
    .s_data  (cal_data),
    .len_sel (avg_len),
    .m_valid (out_valid),
    .m_data  (avg_data)
  );

  adc_cond_narrow #(.CONV_W(CONV_W), .CORE_W(CORE_W)) u_dac (
    .clk     (clk),
    .rst_n   (rst_n),
    .s_valid (dac_in_valid),
    .s_data  ($signed(dac_in)),
    .m_valid (dac_out_valid),
    .m_code  (dac_code)
  );

  assign out_data = avg_data;
  assign dac_out  = dac_code;

  // R7: fixed three-edge latency from strobe in to strobe out
  p_latency_r7: assert property (@(posedge clk) disable iff (!rst_n)
    in_valid |-> ##3 out_valid);
  p_no_spurious_r7: assert property (@(posedge clk) disable iff (!rst_n)
    !in_valid |-> ##3 !out_valid);
endmodule

// File: tb/adc_cond_chan_tb_top.sv
module adc_cond_chan_tb_top;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        in_valid = 1'b0;
  logic [13:0] in_sample = '0;
  logic [17:0] gain = '0;
  logic [17:0] offset = '0;
  logic [1:0]  avg_len = '0;
  logic        out_valid;
  logic [17:0] out_data;
  logic        dac_in_valid = 1'b0;
  logic [17:0] dac_in = '0;
  logic        dac_out_valid;
  logic [13:0] dac_out;

  int n_cmp = 0;
  int n_bad = 0;
  longint hq [8];

  always #5 clk = ~clk;

  adc_cond_chan dut_i (
    .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_sample(in_sample),
    .gain(gain), .offset(offset), .avg_len(avg_len), .out_valid(out_valid),
    .out_data(out_data), .dac_in_valid(dac_in_valid), .dac_in(dac_in),
    .dac_out_valid(dac_out_valid), .dac_out(dac_out)
  );

  task automatic chk(input bit ok, input string req, input longint act, input longint exp);
    n_cmp++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s: actual %0d expected %0d", req, act, exp);
    end
  endtask

  task automatic report();
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  endtask

  function automatic longint clampv(longint v, longint lo, longint hi);
    return (v > hi) ? hi : ((v < lo) ? lo : v);
  endfunction

  // bench model of widen, gain, offset
  function automatic longint model_cal(longint a, longint g, longint o);
    longint w, r;
    w = a * 16;
    r = (w * g + 8192) >>> 14;
    r = clampv(r, -131072, 131071);
    return clampv(r + o, -131072, 131071);
  endfunction

  function automatic longint model_avg(int k);
    longint s = 0;
    for (int i = 0; i < (1 << k); i++) s += hq[i];
    return s >>> k;
  endfunction

  // push one sample, check output after three edges
  task automatic push(input longint a, input longint g, input longint o, input int k, input string req);
    longint v;
    @(negedge clk);
    in_sample = 14'(a); gain = 18'(g); offset = 18'(o); avg_len = 2'(k); in_valid = 1'b1;
    v = model_cal(a, g, o);
    for (int i = 7; i > 0; i--) hq[i] = hq[i-1];
    hq[0] = v;
    @(negedge clk); in_valid = 1'b0;
    @(negedge clk);
    chk(out_valid == 1'b0, "R7 early", out_valid, 0);
    @(negedge clk);
    chk(out_valid == 1'b1, "R7", out_valid, 1);
    chk($signed(out_data) == model_avg(k), req, $signed(out_data), model_avg(k));
    @(negedge clk);
    chk(out_valid == 1'b0, "R7 single", out_valid, 0);
  endtask

  task automatic t_reset();
    chk(out_valid == 0 && dac_out_valid == 0, "R1 valids", {out_valid, dac_out_valid}, 0);
    chk(out_data == 0, "R1 out_data", out_data, 0);
    chk(dac_out == 0, "R1 dac_out", dac_out, 0);
  endtask

  task automatic t_widen();
    push(1, 16384, 0, 0, "R2 plus one");
    push(-1, 16384, 0, 0, "R2 minus one");
    push(8191, 16384, 0, 0, "R2 max");
    push(-8192, 16384, 0, 0, "R2 min");
  endtask

  task automatic t_gain();
    push(8191, 65536, 0, 0, "R3 clip high");
    push(-8192, 65536, 0, 0, "R3 clip low");
    push(-1, 8704, 0, 0, "R3 round half");
    push(3, 5000, 0, 0, "R3 round");
    push(100, -16384, 0, 0, "R3 negative gain");
  endtask

  task automatic t_offset();
    push(10, 16384, 1000, 0, "R4 add");
    push(8000, 16384, 10000, 0, "R4 clip high");
    push(-8000, 16384, -10000, 0, "R4 clip low");
  endtask

  task automatic t_average();
    push(100, 16384, 0, 2, "R5 len4 a");
    push(-37, 16384, 5, 2, "R5 len4 b");
    push(301, 16384, 0, 1, "R5 len2");
    push(7, 16384, -3, 3, "R5 len8");
    // idle: no strobe, then a length change, data must hold
    begin
      logic [17:0] held;
      held = out_data;
      repeat (5) @(negedge clk);
      chk(out_data == held && out_valid == 0, "R6 idle hold", out_data, held);
      avg_len = 2'd0;
      repeat (3) @(negedge clk);
      chk(out_data == held, "R6 length change hold", out_data, held);
    end
  endtask

  task automatic t_switch();
    push(500, 16384, 0, 3, "R10 len8");
    push(-900, 16384, 0, 1, "R10 to len2");
    push(44, 16384, 0, 2, "R10 to len4");
    push(12, 16384, 0, 0, "R10 to len1");
  endtask

  task automatic dac_one(input longint x, input string req);
    longint e;
    logic [13:0] held;
    e = clampv((x + 8) >>> 4, -8192, 8191);
    @(negedge clk); dac_in = 18'(x); dac_in_valid = 1'b1;
    @(negedge clk); dac_in_valid = 1'b0;
    chk(dac_out_valid == 1'b1, "R8 valid", dac_out_valid, 1);
    chk($signed(dac_out) == e, req, $signed(dac_out), e);
    held = dac_out;
    dac_in = 18'(x ^ 12345);
    @(negedge clk);
    chk(dac_out_valid == 1'b0 && dac_out == held, "R9 hold", dac_out, held);
  endtask

  task automatic t_dac();
    dac_one(131071, "R8 clip high");
    dac_one(-131072, "R8 low");
    dac_one(24, "R8 half up");
    dac_one(23, "R8 below half");
    dac_one(-24, "R8 neg half");
    dac_one(-25, "R8 neg below");
  endtask

  initial begin
    #1_000_000;
    n_bad++;
    $display("FAIL watchdog: actual 1 expected 0");
    report();
  end

  initial begin
    for (int i = 0; i < 8; i++) hq[i] = 0;
    repeat (3) @(negedge clk);
    t_reset();
    rst_n = 1'b1;
    repeat (2) @(negedge clk);
    t_widen();
    t_gain();
    t_offset();
    t_average();
    t_switch();
    t_dac();
    report();
  end
endmodule